// File: doc/BRIEF.md
# Serial NOR Flash Sector Erase and Page Program Sequencer

This block walks a serial NOR flash through one complete rewrite of a location. It enables writes, erases the sector that holds a fixed address, waits for the erase to finish, enables writes again, programs one data byte at that address, and waits for the program to finish. It does not shift bits itself. It passes one byte at a time to a separate SPI byte engine through a request/done handshake, and it drives the flash chip select so that the select stays low across every byte of a command. The address and the data byte are parameters.

The block does not wait a fixed worst-case time after erase or program. It reads the flash status byte over and over until the write-in-progress flag clears. A cycle counter acts as a backstop. If the flag is still set when the counter has passed the limit for the current operation, the run ends with an error. A one-cycle `start` pulse launches a run, and `done` pulses once when the run ends, whether it succeeded or failed.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `cs_n` is 1, and `byte_req`, `busy`, `done` and `timeout_err` are all 0.
- R2: A run issues these chip-select frames in order: [0x06], then [0xD8, ADDR[23:16], ADDR[15:8], ADDR[7:0]], then status polls, then [0x06], then [0x02, ADDR[23:16], ADDR[15:8], ADDR[7:0], DATA], then status polls. Each entry is the value on `byte_tx` while `byte_req` is high.
- R3: `cs_n` is low for every byte of a frame and rises only after the last byte of the frame. Before each frame, including the first frame of a run, `cs_n` stays high for at least GAP_CYC clock cycles. `cs_n` is high whenever `busy` is 0.
- R4: `byte_req` is high only while `cs_n` is low. Once raised, `byte_req` stays high until `byte_done` is sampled high, and it is low in the next cycle. Only one byte is requested at a time.
- R5: A status poll is the two-byte frame [0x05, 0x00]. The write-in-progress flag is bit 0 of the `byte_rx` value returned with the second byte. If that bit is 1, the same poll is repeated. If it is 0, the sequence moves on. All other bits of the status byte are ignored.
- R6: The timeout counter starts when the erase or program frame ends. If a poll still shows bit 0 set after ERASE_TMO cycles (erase) or PROG_TMO cycles (program), the block pulses `done` with `timeout_err` at 1 and returns to idle. No further frame follows. `timeout_err` stays at 1 until the next accepted `start`.
- R7: A `start` pulse while `busy` is high has no effect on the frames issued or on the number of `done` pulses.
- R8: After the final program poll reads bit 0 as 0, `done` is high for exactly one cycle and `timeout_err` is 0.
- R9: `busy` rises in the cycle after an accepted `start`. It is 0 in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches a run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| timeout_err | output | 1 | The last run ended because a poll timed out |
| cs_n | output | 1 | Flash chip select, active low |
| byte_req | output | 1 | Request to the byte engine to transfer `byte_tx` |
| byte_tx | output | 8 | Byte to shift out, stable while `byte_req` is high |
| byte_rx | input | 8 | Byte shifted in, valid with `byte_done` |
| byte_done | input | 1 | Byte engine has finished the current byte |

## Verification
The hardest condition to reach is a poll that keeps reading "busy" until the counter expires, and to reach it in either of the two waiting phases. The bench's flash model returns the write-in-progress bit from a programmable count of busy answers per phase, with the other status bits set. A very large count keeps the flag stuck, which forces a timeout in the erase poll in one run and in the program poll in another. Sweeps over busy-poll counts and byte-engine latencies change how the gap, the handshake and the poll repetition line up.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter logic [23:0] ADDR      = 24'h010000,
  parameter logic [7:0]  DATA      = 8'hA5,
  parameter int unsigned GAP_CYC   = 10,
  parameter int unsigned ERASE_TMO = 150_000_000,
  parameter int unsigned PROG_TMO  = 250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic       timeout_err,
  output logic       cs_n,
  output logic       byte_req,
  output logic [7:0] byte_tx,
  input  logic [7:0] byte_rx,
  input  logic       byte_done
);
  localparam int unsigned TMO_MAX = (ERASE_TMO > PROG_TMO) ? ERASE_TMO : PROG_TMO;
  localparam int TW = $clog2(TMO_MAX + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [7:0] OP_WREN = 8'h06, OP_ERASE = 8'hD8, OP_STAT = 8'h05, OP_PROG = 8'h02;
  localparam int WIP_BIT = 0;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_XFER, S_NEXT} st_t;
  typedef enum logic [2:0] {F_WEN1, F_ERASE, F_POLL1, F_WEN2, F_PROG, F_POLL2} fr_t;

  st_t st;
  fr_t fr;
  logic [2:0]    idx, last_idx;
  logic [GW-1:0] gcnt;
  logic [TW-1:0] tcnt;

  wire polling = (fr == F_POLL1) || (fr == F_POLL2);
  wire wip     = byte_rx[WIP_BIT];
  wire expired = tcnt >= ((fr == F_POLL1) ? TW'(ERASE_TMO) : TW'(PROG_TMO));

  assign busy = (st != S_IDLE);

  always_comb begin
    byte_tx  = 8'h00;
    last_idx = 3'd0;
    case (fr)
      F_WEN1, F_WEN2: byte_tx = OP_WREN;
      F_ERASE, F_PROG: begin
        last_idx = (fr == F_PROG) ? 3'd4 : 3'd3;
        case (idx)
          3'd0:    byte_tx = (fr == F_PROG) ? OP_PROG : OP_ERASE;
          3'd1:    byte_tx = ADDR[23:16];
          3'd2:    byte_tx = ADDR[15:8];
          3'd3:    byte_tx = ADDR[7:0];
          default: byte_tx = DATA;
        endcase
      end
      F_POLL1, F_POLL2: begin
        last_idx = 3'd1;
        byte_tx  = (idx == 3'd0) ? OP_STAT : 8'h00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      fr          <= F_WEN1;
      idx         <= '0;
      gcnt        <= '0;
      tcnt        <= '0;
      cs_n        <= 1'b1;
      byte_req    <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (polling && tcnt != '1) tcnt <= tcnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st          <= S_GAP;
          fr          <= F_WEN1;
          gcnt        <= '0;
          timeout_err <= 1'b0;
        end
        S_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) begin
            cs_n     <= 1'b0;
            byte_req <= 1'b1;
            idx      <= '0;
            st       <= S_XFER;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        S_XFER: if (byte_done) begin
          byte_req <= 1'b0;
          if (idx == last_idx) begin
            cs_n <= 1'b1;
            gcnt <= '0;
            st   <= S_GAP;
            if (!polling) begin
              fr <= fr_t'(fr + 3'd1);
              if (fr == F_ERASE || fr == F_PROG) tcnt <= '0;
            end else if (!wip) begin
              if (fr == F_POLL2) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                fr <= F_WEN2;
              end
            end else if (expired) begin
              st          <= S_IDLE;
              done        <= 1'b1;
              timeout_err <= 1'b1;
            end
          end else begin
            idx <= idx + 1'b1;
            st  <= S_NEXT;
          end
        end
        S_NEXT: begin
          byte_req <= 1'b1;
          st       <= S_XFER;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int unsigned GAP_CYC = 10
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic timeout_err,
  input logic cs_n,
  input logic byte_req,
  input logic byte_done
);
  localparam int GW = $clog2(GAP_CYC + 1);
  logic [GW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt < GW'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r3_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= GW'(GAP_CYC));
  a_r3_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  a_r4_req_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> !cs_n);
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req && !byte_done |=> byte_req);
  a_r4_req_release: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req && byte_done |=> !byte_req);
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> done);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .timeout_err(timeout_err), .cs_n(cs_n), .byte_req(byte_req), .byte_done(byte_done)
);

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/1ps
module flash_prog_seq_bench;
  localparam logic [23:0] T_ADDR = 24'h3C5A96;
  localparam logic [7:0]  T_DATA = 8'hE7;
  localparam int GAP = 4;
  localparam int STUCK = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, timeout_err, cs_n, byte_req, byte_done;
  logic [7:0] byte_tx, byte_rx;

  always #2.5 clk = ~clk;

  flash_prog_seq #(.ADDR(T_ADDR), .DATA(T_DATA), .GAP_CYC(GAP), .ERASE_TMO(300), .PROG_TMO(200))
    u_flash_prog_seq (.clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .timeout_err(timeout_err), .cs_n(cs_n), .byte_req(byte_req), .byte_tx(byte_tx),
      .byte_rx(byte_rx), .byte_done(byte_done));

  int checks = 0, errors = 0;
  bit finished = 0;

  // flash and byte engine model
  int lat = 0, ne = 0, np = 0;
  bit clr = 0;
  logic [7:0] lg_b [0:255];
  int lg_f [0:255];
  int lg_n, frame_no, bidx, wcnt, polls_e, polls_p, done_cnt, hs_bad, gap_bad, hi_run;
  bit seen_pp, err_at_done, busy_at_done, p_req, p_done, p_cs;
  logic [7:0] first_b;

  initial begin
    byte_done = 1'b0;
    byte_rx = 8'h00;
    p_req = 0; p_done = 0; p_cs = 1; hi_run = 0;
    forever begin
      @(negedge clk);
      if (clr) begin
        lg_n = 0; frame_no = 0; bidx = 0; wcnt = 0; polls_e = 0; polls_p = 0;
        done_cnt = 0; hs_bad = 0; gap_bad = 0; seen_pp = 0; err_at_done = 0; busy_at_done = 0;
      end
      byte_done = 1'b0;
      if (byte_req && cs_n) hs_bad++;
      if (p_done && byte_req) hs_bad++;
      if (p_req && !p_done && !byte_req) hs_bad++;
      if (cs_n) hi_run++;
      else begin
        if (p_cs) begin
          if (hi_run < GAP) gap_bad++;
          frame_no++;
          bidx = 0;
        end
        hi_run = 0;
      end
      if (done) begin
        done_cnt++;
        err_at_done = timeout_err;
        busy_at_done = busy;
      end
      if (byte_req && !cs_n) begin
        if (wcnt == lat) begin
          byte_done = 1'b1;
          wcnt = 0;
          byte_rx = 8'h5A;
          if (bidx == 0) begin
            first_b = byte_tx;
            if (byte_tx == 8'h02) seen_pp = 1;
          end else if (first_b == 8'h05 && bidx == 1) begin
            if (seen_pp) begin byte_rx = 8'hFE | 8'((polls_p < np) ? 1 : 0); polls_p++; end
            else begin byte_rx = 8'hFE | 8'((polls_e < ne) ? 1 : 0); polls_e++; end
          end
          if (lg_n < 256) begin lg_b[lg_n] = byte_tx; lg_f[lg_n] = frame_no; lg_n++; end
          bidx++;
        end else wcnt++;
      end else wcnt = 0;
      p_req = byte_req; p_done = byte_done; p_cs = cs_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [7:0] ex_b [0:63];
  int ex_f [0:63];
  int ex_n;

  task automatic add(input int f, input logic [7:0] b);
    ex_b[ex_n] = b; ex_f[ex_n] = f; ex_n++;
  endtask

  task automatic build_exp(input int e, input int p);
    int f = 1;
    ex_n = 0;
    add(f, 8'h06); f++;
    add(f, 8'hD8); add(f, T_ADDR[23:16]); add(f, T_ADDR[15:8]); add(f, T_ADDR[7:0]); f++;
    for (int k = 0; k <= e; k++) begin add(f, 8'h05); add(f, 8'h00); f++; end
    add(f, 8'h06); f++;
    add(f, 8'h02); add(f, T_ADDR[23:16]); add(f, T_ADDR[15:8]); add(f, T_ADDR[7:0]); add(f, T_DATA); f++;
    for (int k = 0; k <= p; k++) begin add(f, 8'h05); add(f, 8'h00); f++; end
  endtask

  task automatic launch(input int e, input int p, input int l);
    ne = e; np = p; lat = l;
    @(posedge clk); clr = 1; @(posedge clk); clr = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", busy, 1);
    repeat (20) @(negedge clk);
    start = 1'b1;  // R7: ignored, block is busy
    @(negedge clk); start = 1'b0;
    for (int w = 0; w < 20000 && done_cnt == 0; w++) @(negedge clk);
    chk(done_cnt == 1, "R8 run finished", done_cnt, 1);
    chk(busy_at_done == 1'b0, "R9 busy low at done", busy_at_done, 0);
  endtask

  task automatic run_ok(input int e, input int p, input int l);
    int bad = 0, n0;
    launch(e, p, l);
    n0 = lg_n;
    repeat (30) @(negedge clk);
    chk(lg_n == n0 && done_cnt == 1 && cs_n, "R7 no extra run", lg_n, n0);
    chk(err_at_done == 1'b0, "R8 no error", err_at_done, 0);
    build_exp(e, p);
    chk(lg_n == ex_n, "R2 byte count", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++)
      if (lg_b[i] !== ex_b[i] || lg_f[i] != ex_f[i]) bad++;
    chk(bad == 0, "R2 frame bytes", bad, 0);
    chk(polls_e == e + 1, "R5 erase polls", polls_e, e + 1);
    chk(polls_p == p + 1, "R5 program polls", polls_p, p + 1);
    chk(gap_bad == 0, "R3 chip select gap", gap_bad, 0);
    chk(hs_bad == 0, "R4 handshake", hs_bad, 0);
  endtask

  task automatic run_to(input bit in_prog);
    int pre, bad = 0;
    launch(in_prog ? 0 : STUCK, in_prog ? STUCK : 0, 1);
    repeat (30) @(negedge clk);
    chk(err_at_done == 1'b1, "R6 timeout flagged", err_at_done, 1);
    chk(timeout_err === 1'b1 && cs_n && !busy, "R6 idle with error held", timeout_err, 1);
    build_exp(0, 0);
    pre = in_prog ? 13 : 5;
    for (int i = 0; i < pre; i++)
      if (lg_b[i] !== ex_b[i]) bad++;
    for (int i = pre; i < lg_n; i++)
      if (lg_b[i] !== (((i - pre) % 2 == 0) ? 8'h05 : 8'h00)) bad++;
    chk(bad == 0, "R6 only polls after last operation", bad, 0);
    chk(((lg_n - pre) % 2 == 0) && (lg_n - pre) >= 4, "R6 repeated polls", lg_n - pre, 4);
    chk(hs_bad == 0 && gap_bad == 0, "R6 framing during timeout", hs_bad + gap_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && byte_req === 1'b0, "R1 bus idle in reset", {cs_n, byte_req}, 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && timeout_err === 1'b0 && cs_n === 1'b1,
        "R1 reset state", {busy, done, timeout_err, cs_n}, 1);
    for (int l = 0; l < 3; l++)
      for (int e = 0; e < 4; e++)
        for (int p = 0; p < 4; p++)
          run_ok(e, p, l);
    run_to(1'b0);
    run_ok(1, 0, 1);
    run_to(1'b1);
    run_ok(0, 2, 2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule